// File: doc/BRIEF.md
# Segmented Cartridge Bank-Switch Mapper

This block translates CPU accesses inside a 4 KB cartridge window (0x1000–0x1FFF of a 13-bit address space) into physical addresses for an external ROM of up to 64 KB and an external RAM of up to 32 KB. The window is split into eight 512-byte slots. Each slot carries a descriptor: a bank number, a ROM/RAM flag, a half/port flag and a valid flag. For each access the block drives a ROM or RAM address, a select for each memory, a RAM write enable and a read-data-valid flag. The ROM and RAM arrays themselves sit outside the block.

Software remaps the window by writing a control byte to one of two hotspot addresses. Bits 7:6 of the byte pick a destination segment and bits 5:0 pick a bank. A ROM switch maps a 1 KB bank onto two adjacent slots. A RAM switch maps a 512-byte bank onto a read slot in the lower half of the window and onto a write slot 0x800 above it. This can displace half of a ROM segment that was mapped earlier, while the other half stays readable.

Top module: `seg_bank_mapper`

## Requirements
- R1: After reset, slots 6 and 7 (0x1C00–0x1FFF) hold the lower and upper halves of ROM bank 0, so a read there drives rom_addr = {6'd0, addr[9:0]} with rom_sel and data_valid high. Slots 0–5 start undefined.
- R2: A write with cpu_wr to address 0x003F and byte {s[1:0], b[5:0]} takes effect from the next clock edge. Reads in 0x1000+s*0x400 .. +0x3FF then give rom_sel=1, data_valid=1 and rom_addr = {b, addr[9:0]} (16 bits).
- R3: A write with cpu_wr to address 0x003E and byte {r[1:0], b[5:0]} maps RAM bank b to read slot r (0x1000+r*0x200). Reads there give ram_sel=1, data_valid=1, ram_we=0 and ram_addr = {b, addr[8:0]} (15 bits).
- R4: The same RAM switch maps write slot r+4 (0x1800+r*0x200). A write there gives ram_sel=1, ram_we=1 and the same ram_addr.
- R5: A RAM switch replaces only slots r and r+4. The other halves of the ROM segments that share those slots keep their ROM mapping.
- R6: An access to an undefined slot asserts no select, no ram_we and no data_valid.
- R7: A read that hits a RAM write slot returns data_valid=0 with no select. A write that hits a ROM slot or a RAM read slot leaves ram_we=0.
- R8: Only a cpu_wr to exactly 0x003E or 0x003F changes the mapping. Other addresses such as 0x013E or 0x003D, and reads of the hotspots, change nothing. A hotspot write asserts no memory select.
- R9: Accesses with addr[12]=0 assert no select and no data_valid.
- R10: RAM segments 0–3 mapped to banks n..n+3 form one contiguous 2 KB region. A read at 0x1000+k gives ram_addr = n*512+k for k in 0..0x7FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 13 | CPU address, low 13 bits |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data (hotspot control byte) |
| rom_addr | output | 16 | Physical ROM byte address |
| rom_sel | output | 1 | ROM read select |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_sel | output | 1 | RAM select (read or write) |
| ram_we | output | 1 | RAM write enable |
| data_valid | output | 1 | Read returns valid data |

## Verification
The hardest case is a partly overlaid ROM segment, where one 512-byte half was replaced by a RAM port and the other half must still decode to the original ROM bank. The stimulus maps ROM banks into segments 0 and 2 first and then maps a single RAM segment over them. It then probes both halves of each segment, and the write port, with reads and with writes. A later pass maps four RAM segments with consecutive banks and walks the edges of the resulting 2 KB region, including the former reset-vector slots.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = 6;
    localparam int OFS_W   = 9;
    localparam int SLOT_W  = 3;
    localparam int SEG_W   = 2;
    localparam int N_SLOT  = 1 << SLOT_W;
    localparam int N_SEG   = 1 << SEG_W;
    localparam int ROM_AW  = BANK_W + 1 + OFS_W;
    localparam int RAM_AW  = BANK_W + OFS_W;

    typedef struct packed {
        logic              valid;
        logic              is_ram;
        logic              upper;   // ROM: upper half; RAM: write port
        logic [BANK_W-1:0] bank;
    } slot_t;

    typedef slot_t [N_SLOT-1:0] slot_tab_t;

    function automatic slot_tab_t reset_table();
        slot_tab_t t;
        for (int i = 0; i < N_SLOT; i++) begin
            t[i] = '{valid: 1'b0, is_ram: 1'b0, upper: 1'b0, bank: '0};
        end
        t[N_SLOT-2] = '{valid: 1'b1, is_ram: 1'b0, upper: 1'b0, bank: '0};
        t[N_SLOT-1] = '{valid: 1'b1, is_ram: 1'b0, upper: 1'b1, bank: '0};
        return t;
    endfunction
endpackage

// File: rtl/hotspot_decode.sv
module hotspot_decode
    import seg_map_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_HOT = 13'h003E,
    parameter logic [ADDR_W-1:0] ROM_HOT = 13'h003F
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hot_ram,
    output logic              hot_rom
);
    always_comb begin
        hot_ram = wr && (addr == RAM_HOT);
        hot_rom = wr && (addr == ROM_HOT);
    end
endmodule

// File: rtl/slot_table.sv
module slot_table
    import seg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hot_ram,
    input  logic              hot_rom,
    input  logic [DATA_W-1:0] wdata,
    output slot_tab_t         tab
);
    typedef struct packed {
        slot_tab_t slots;
    } state_t;

    state_t st_d, st_q;

    logic [SEG_W-1:0]  seg_sel;
    logic [BANK_W-1:0] bank_sel;

    always_comb begin
        seg_sel  = wdata[DATA_W-1 -: SEG_W];
        bank_sel = wdata[BANK_W-1:0];
        st_d     = st_q;
        if (hot_rom) begin
            st_d.slots[{seg_sel, 1'b0}] = '{valid: 1'b1, is_ram: 1'b0, upper: 1'b0, bank: bank_sel};
            st_d.slots[{seg_sel, 1'b1}] = '{valid: 1'b1, is_ram: 1'b0, upper: 1'b1, bank: bank_sel};
        end
        if (hot_ram) begin
            st_d.slots[{1'b0, seg_sel}] = '{valid: 1'b1, is_ram: 1'b1, upper: 1'b0, bank: bank_sel};
            st_d.slots[{1'b1, seg_sel}] = '{valid: 1'b1, is_ram: 1'b1, upper: 1'b1, bank: bank_sel};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.slots <= reset_table();
        else        st_q       <= st_d;
    end

    assign tab = st_q.slots;

    for (genvar g = 0; g < N_SEG; g++) begin : g_seg_chk
        // R2: ROM switch fills both halves of the chosen segment
        p_rom_switch_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (hot_rom && !hot_ram && wdata[DATA_W-1 -: SEG_W] == g) |=>
            (tab[2*g].valid && !tab[2*g].is_ram && tab[2*g+1].upper &&
             tab[2*g].bank == $past(wdata[BANK_W-1:0]) &&
             tab[2*g+1].bank == $past(wdata[BANK_W-1:0])));
        // R3, R4: RAM switch fills read slot g and write slot g+4
        p_ram_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hot_ram && wdata[DATA_W-1 -: SEG_W] == g) |=>
            (tab[g].is_ram && !tab[g].upper && tab[g+N_SEG].is_ram &&
             tab[g+N_SEG].upper && tab[g].bank == $past(wdata[BANK_W-1:0])));
    end

    // R8: without a hotspot write the table holds
    p_table_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_ram && !hot_rom) |=> $stable(tab));
endmodule

// File: rtl/access_decode.sv
module access_decode
    import seg_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  slot_tab_t         tab,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_sel,
    output logic              ram_we,
    output logic              data_valid
);
    slot_t            ent;
    logic             in_win;
    logic [OFS_W-1:0] ofs;
    logic             rom_hit, ram_rd_hit, ram_wr_hit;

    always_comb begin
        in_win     = addr[ADDR_W-1];
        ent        = tab[addr[ADDR_W-2 -: SLOT_W]];
        ofs        = addr[OFS_W-1:0];
        rom_hit    = in_win && ent.valid && !ent.is_ram;
        ram_rd_hit = in_win && ent.valid &&  ent.is_ram && !ent.upper;
        ram_wr_hit = in_win && ent.valid &&  ent.is_ram &&  ent.upper;
        rom_addr   = {ent.bank, ent.upper, ofs};
        ram_addr   = {ent.bank, ofs};
        rom_sel    = rd && rom_hit;
        ram_we     = wr && ram_wr_hit;
        ram_sel    = (rd && ram_rd_hit) || ram_we;
        data_valid = rom_sel || (rd && ram_rd_hit);
    end
endmodule

// File: rtl/seg_bank_mapper.sv
module seg_bank_mapper
    import seg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_sel,
    output logic              ram_we,
    output logic              data_valid
);
    logic      hot_ram, hot_rom;
    slot_tab_t tab;

    hotspot_decode i_hot (
        .addr    (cpu_addr),
        .wr      (cpu_wr),
        .hot_ram (hot_ram),
        .hot_rom (hot_rom)
    );

    slot_table i_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .hot_ram (hot_ram),
        .hot_rom (hot_rom),
        .wdata   (cpu_wdata),
        .tab     (tab)
    );

    access_decode i_dec (
        .addr       (cpu_addr),
        .rd         (cpu_rd),
        .wr         (cpu_wr),
        .tab        (tab),
        .rom_addr   (rom_addr),
        .rom_sel    (rom_sel),
        .ram_addr   (ram_addr),
        .ram_sel    (ram_sel),
        .ram_we     (ram_we),
        .data_valid (data_valid)
    );

    // R4: a RAM write only lands in the upper (write-port) half of the window
    p_we_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2] && ram_sel));
    // R7: valid data only on reads
    p_valid_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (cpu_rd && (rom_sel || ram_sel)));
    // R8: hotspot write touches no memory
    p_hot_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_ram || hot_rom) |-> (!rom_sel && !ram_sel && !ram_we));
    // R9: outside the window nothing is selected
    p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[ADDR_W-1] |-> (!rom_sel && !ram_sel && !data_valid));
    // R6: never both memories at once
    p_one_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel}));
endmodule

// File: tb/test_seg_bank_mapper.sv
`timescale 1ns/1ps
module test_seg_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] rom_addr;
    logic        rom_sel;
    logic [14:0] ram_addr;
    logic        ram_sel;
    logic        ram_we;
    logic        data_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_bank_mapper i_seg_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rom_addr(rom_addr),
        .rom_sel(rom_sel), .ram_addr(ram_addr), .ram_sel(ram_sel),
        .ram_we(ram_we), .data_valid(data_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic hot(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
        chk("R8", "hotspot sel", {rom_sel, ram_sel, ram_we}, 3'b000);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic access(input logic [12:0] a, input logic rd, input logic wr);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h00;
        #1;
    endtask

    task automatic rom_read(input string req, input logic [12:0] a, input logic [15:0] exp);
        access(a, 1'b1, 1'b0);
        chk(req, "rom flags", {rom_sel, ram_sel, data_valid}, 3'b101);
        chk(req, "rom_addr", rom_addr, exp);
    endtask

    task automatic ram_read(input string req, input logic [12:0] a, input logic [14:0] exp);
        access(a, 1'b1, 1'b0);
        chk(req, "ram rd flags", {rom_sel, ram_sel, ram_we, data_valid}, 4'b0101);
        chk(req, "ram_addr", ram_addr, exp);
    endtask

    task automatic ram_write(input string req, input logic [12:0] a, input logic [14:0] exp);
        access(a, 1'b0, 1'b1);
        chk(req, "ram wr flags", {rom_sel, ram_sel, ram_we, data_valid}, 4'b0110);
        chk(req, "ram_addr", ram_addr, exp);
    endtask

    task automatic no_read(input string req, input logic [12:0] a);
        access(a, 1'b1, 1'b0);
        chk(req, "no read", {rom_sel, ram_sel, ram_we, data_valid}, 4'b0000);
    endtask

    task automatic no_write(input string req, input logic [12:0] a);
        access(a, 1'b0, 1'b1);
        chk(req, "no write", {ram_sel, ram_we}, 2'b00);
    endtask

    task automatic t_reset();
        rom_read("R1", 13'h1C00, 16'h0000);
        rom_read("R1", 13'h1FFF, 16'h03FF);
        no_read("R1", 13'h1000);
        no_read("R6", 13'h1500);
        no_write("R6", 13'h1600);
        no_write("R7", 13'h1E00);
    endtask

    task automatic t_rom();
        hot(13'h003F, {2'd0, 6'd5});
        rom_read("R2", 13'h1123, 16'h1523);
        hot(13'h003F, {2'd2, 6'd63});
        rom_read("R2", 13'h1A05, 16'hFE05);
        rom_read("R2", 13'h1834, 16'hFC34);
    endtask

    task automatic t_ram_overlay();
        hot(13'h003E, {2'd1, 6'd9});
        ram_read("R3", 13'h1234, 15'h1234);
        ram_write("R4", 13'h1A34, 15'h1234);
        rom_read("R5", 13'h1034, 16'h1434);
        rom_read("R5", 13'h1834, 16'hFC34);
        no_read("R7", 13'h1A34);
        no_write("R7", 13'h1034);
        no_write("R7", 13'h1234);
    endtask

    task automatic t_hotspot_exact();
        access(13'h013E, 1'b0, 1'b1);
        access(13'h003D, 1'b0, 1'b1);
        access(13'h003F, 1'b1, 1'b0);
        rom_read("R8", 13'h1000, 16'h1400);
        rom_read("R8", 13'h1C10, 16'h0010);
        no_read("R9", 13'h0800);
        no_write("R9", 13'h0A00);
    endtask

    task automatic t_contig();
        hot(13'h003E, {2'd0, 6'd16});
        hot(13'h003E, {2'd1, 6'd17});
        hot(13'h003E, {2'd2, 6'd18});
        hot(13'h003E, {2'd3, 6'd19});
        ram_read("R10", 13'h1000, 15'h2000);
        ram_read("R10", 13'h1300, 15'h2300);
        ram_read("R10", 13'h17FF, 15'h27FF);
        ram_write("R10", 13'h1FFF, 15'h27FF);
        no_read("R7", 13'h1C00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom();
        t_ram_overlay();
        t_hotspot_exact();
        t_contig();
        access(13'h0000, 1'b0, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule